// File: doc/BRIEF.md
# Fractional Core-Timer Prescaler

This block produces the count of a free-running core timer. One of two clock-enable strobes in the host clock domain (a crystal-derived strobe or a bus-clock strobe) is picked as the source. A fractional divider then turns those source strobes into timer increments at a rate of source_rate * 2^31 / prescaler. Each increment adds either 1 or 2 to the counter, as a control bit chooses.

Software sets the block up through two registers: a control register and a prescaler register. Both come back as zero after reset, which leaves the timer stopped until a prescaler is programmed. The divider keeps a phase accumulator that gains 2^(PRE_W-1) on every selected strobe and gives up one prescaler value each time it issues an increment. Writing the prescaler clears that accumulator, so every new ratio starts from a known phase.

Top module: `core_timer_prescaler`

## Requirements
- R1: While reset is asserted and right after its release, timer_o is 0, tick_o is 0, and both registers read back as 0.
- R2: Control bit 8 chooses the source. When it is 0, xtal_tick_i is the source and bus_tick_i has no effect. When it is 1, bus_tick_i is the source and xtal_tick_i has no effect. A cycle with no strobe on the selected source never increments the timer.
- R3: Control bit 9 sets the increment size. Each increment adds 1 when the bit is 0 and 2 when it is 1.
- R4: A nonzero prescaler at or below 0x80000000 gives one increment for every selected strobe. 0x80000000 is the 1:1 setting.
- R5: A prescaler of 0 stops the timer. No increment is issued, whatever strobes arrive.
- R6: A prescaler P above 0x80000000 counts the selected strobes n = 1, 2, ... since the last prescaler write. The n-th strobe gives an increment exactly when floor(n*2^31/P) is greater than floor((n-1)*2^31/P).
- R7: A write with reg_addr_i = 0 loads the control register, which keeps only bits 9 and 8; all other bits read 0. A write with reg_addr_i = 1 loads the full prescaler. reg_rdata_o shows the register chosen by reg_addr_i in the same cycle.
- R8: A register write takes effect from the next cycle on. A strobe that arrives in the same cycle as the write is handled with the old settings.
- R9: The counter wraps modulo 2^CNT_W.
- R10: tick_o is high for exactly those cycles in which timer_o has just advanced. Otherwise timer_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_tick_i | input | 1 | Crystal-source clock enable |
| bus_tick_i | input | 1 | Bus-source clock enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 control, 1 prescaler |
| reg_wdata_i | input | PRE_W | Register write data |
| reg_rdata_o | output | PRE_W | Read data for the selected register |
| timer_o | output | CNT_W | Timer count |
| tick_o | output | 1 | High in the cycle after the count advanced |

## Verification
The bench builds the block with CNT_W set to 12 and keeps PRE_W at 32. A 12-bit counter wraps within about two thousand strobes, which puts the modulo rollover of R9 in reach, including a wrap that happens partway through a step of 2. Keeping the prescaler at its full 32 bits means the exact 1:1 setting, saturating values below it, and fractional values such as 0xC0000000, 0x90000000 and 0xFFFFFFFF can all be compared against a floor-based rate model.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

  typedef enum logic {
    REG_CTRL  = 1'b0,
    REG_PRESC = 1'b1
  } cpt_reg_e;

  typedef struct packed {
    logic dbl_step;
    logic alt_src;
  } cpt_ctrl_t;

  localparam int unsigned SRC_BIT_DEF  = 8;
  localparam int unsigned STEP_BIT_DEF = 9;

endpackage

// File: rtl/cpt_regs.sv
module cpt_regs
  import cpt_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SRC_BIT  = SRC_BIT_DEF,
  parameter int unsigned STEP_BIT = STEP_BIT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output cpt_ctrl_t         ctrl_o,
  output logic [DATA_W-1:0] presc_o,
  output logic              presc_wr_o
);

  cpt_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] presc_q;
  logic              ctrl_wr;

  assign ctrl_wr    = we_i && (cpt_reg_e'(addr_i) == REG_CTRL);
  assign presc_wr_o = we_i && (cpt_reg_e'(addr_i) == REG_PRESC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      presc_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.alt_src  <= wdata_i[SRC_BIT];
        ctrl_q.dbl_step <= wdata_i[STEP_BIT];
      end
      if (presc_wr_o) presc_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (cpt_reg_e'(addr_i))
      REG_CTRL: begin
        rdata_o[SRC_BIT]  = ctrl_q.alt_src;
        rdata_o[STEP_BIT] = ctrl_q.dbl_step;
      end
      REG_PRESC: rdata_o = presc_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign presc_o = presc_q;

endmodule

// File: rtl/cpt_frac_div.sv
module cpt_frac_div #(
  parameter int unsigned PRE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             inc_o
);

  localparam logic [PRE_W:0] UNITY = (PRE_W+1)'(1) << (PRE_W-1);

  logic [PRE_W-1:0] acc_q;
  logic [PRE_W:0]   sum;
  logic [PRE_W:0]   presc_x;
  logic             stopped;
  logic             sat;
  logic             hit;

  assign presc_x = {1'b0, presc_i};
  assign stopped = (presc_i == '0);
  // at or above 1:1 the rate is capped at one increment per strobe
  assign sat     = !stopped && (presc_x <= UNITY);
  assign sum     = {1'b0, acc_q} + UNITY;
  assign hit     = (sum >= presc_x);
  assign inc_o   = en_i && !stopped && (sat || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (en_i && !stopped && !sat) begin
      acc_q <= hit ? PRE_W'(sum - presc_x) : sum[PRE_W-1:0];
    end
  end

endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dbl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic [CNT_W-1:0] step;

  assign step = dbl_i ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= inc_i;
      if (inc_i) cnt_q <= cnt_q + step;
    end
  end

  assign cnt_o  = cnt_q;
  assign tick_o = tick_q;

endmodule

// File: rtl/core_timer_prescaler.sv
module core_timer_prescaler
  import cpt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned PRE_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xtal_tick_i,
  input  logic             bus_tick_i,
  input  logic             reg_we_i,
  input  logic             reg_addr_i,
  input  logic [PRE_W-1:0] reg_wdata_i,
  output logic [PRE_W-1:0] reg_rdata_o,
  output logic [CNT_W-1:0] timer_o,
  output logic             tick_o
);

  cpt_ctrl_t        ctrl;
  logic [PRE_W-1:0] presc_q;
  logic             presc_wr;
  logic             alt_src;
  logic             dbl_step;
  logic             src_stb;
  logic             inc;

  cpt_regs #(
    .DATA_W  (PRE_W),
    .SRC_BIT (SRC_BIT_DEF),
    .STEP_BIT(STEP_BIT_DEF)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .ctrl_o    (ctrl),
    .presc_o   (presc_q),
    .presc_wr_o(presc_wr)
  );

  assign alt_src  = ctrl.alt_src;
  assign dbl_step = ctrl.dbl_step;
  assign src_stb  = alt_src ? bus_tick_i : xtal_tick_i;

  cpt_frac_div #(
    .PRE_W(PRE_W)
  ) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (src_stb),
    .clr_i  (presc_wr),
    .presc_i(presc_q),
    .inc_o  (inc)
  );

  cpt_counter #(
    .CNT_W(CNT_W)
  ) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .dbl_i (dbl_step),
    .cnt_o (timer_o),
    .tick_o(tick_o)
  );

endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned PRE_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             xtal_tick_i,
  input logic             bus_tick_i,
  input logic [CNT_W-1:0] timer_o,
  input logic             tick_o,
  input logic [PRE_W-1:0] presc_i,
  input logic             alt_src_i,
  input logic             dbl_i
);

  localparam logic [PRE_W-1:0] UNITY = PRE_W'(1) << (PRE_W-1);

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(timer_o)); // R10

  AST_STEP_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (timer_o == $past(timer_o) + ($past(dbl_i) ? CNT_W'(2) : CNT_W'(1)))); // R3

  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_i == '0) |=> !tick_o); // R5

  AST_SRC_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alt_src_i ? bus_tick_i : xtal_tick_i) |=> !tick_o); // R2

  AST_UNITY_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((presc_i != '0) && (presc_i <= UNITY) && (alt_src_i ? bus_tick_i : xtal_tick_i)) |=> tick_o); // R4

endmodule

bind core_timer_prescaler cpt_checker #(
  .CNT_W(CNT_W),
  .PRE_W(PRE_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xtal_tick_i(xtal_tick_i),
  .bus_tick_i (bus_tick_i),
  .timer_o    (timer_o),
  .tick_o     (tick_o),
  .presc_i    (presc_q),
  .alt_src_i  (alt_src),
  .dbl_i      (dbl_step)
);

// File: tb/test_core_timer_prescaler.sv
`timescale 1ns/1ps
module test_core_timer_prescaler;

  localparam int unsigned CNT_W = 12;
  localparam int unsigned PRE_W = 32;
  localparam longint unsigned UNITY = 64'h8000_0000;
  localparam longint unsigned CMASK = (64'd1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             xtal_tick_i = 1'b0;
  logic             bus_tick_i = 1'b0;
  logic             reg_we_i = 1'b0;
  logic             reg_addr_i = 1'b0;
  logic [PRE_W-1:0] reg_wdata_i = '0;
  logic [PRE_W-1:0] reg_rdata_o;
  logic [CNT_W-1:0] timer_o;
  logic             tick_o;

  always #2.5 clk = ~clk;

  core_timer_prescaler #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_core_timer_prescaler (
    .clk_i(clk), .rst_ni(rst_ni), .xtal_tick_i(xtal_tick_i), .bus_tick_i(bus_tick_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .timer_o(timer_o), .tick_o(tick_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 0;
  string req    = "R1";

  longint unsigned m_timer = 0;
  bit              m_tick  = 0;
  longint unsigned m_ctrl  = 0;
  longint unsigned m_presc = 0;
  longint unsigned m_n     = 0;

  task automatic check(input string r, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check(req, longint'(timer_o), m_timer);
    check((req == "R10") ? "R10" : {req, "/R10"}, longint'(tick_o), longint'(m_tick));
    check("R7", longint'(reg_rdata_o), reg_addr_i ? m_presc : m_ctrl);
  endtask

  task automatic model_edge(input bit xt, input bit bt, input bit we, input bit ad,
                            input longint unsigned wd);
    bit src;
    bit inc;
    src = m_ctrl[8] ? bt : xt;
    inc = 0;
    if (src && m_presc != 0) begin
      m_n++;
      if (m_presc <= UNITY) inc = 1;
      else inc = ((m_n * UNITY) / m_presc) != (((m_n - 1) * UNITY) / m_presc);
    end
    m_tick = inc;
    if (inc) m_timer = (m_timer + (m_ctrl[9] ? 64'd2 : 64'd1)) & CMASK;
    if (we) begin
      if (!ad) m_ctrl = wd & 64'h300;
      else begin
        m_presc = wd & 64'hFFFF_FFFF;
        m_n = 0;
      end
    end
  endtask

  task automatic cyc(input bit xt, input bit bt, input bit we, input bit ad,
                     input longint unsigned wd);
    @(negedge clk);
    cmp_all();
    xtal_tick_i = xt;
    bus_tick_i  = bt;
    reg_we_i    = we;
    reg_addr_i  = ad;
    reg_wdata_i = PRE_W'(wd);
    @(posedge clk);
    model_edge(xt, bt, we, ad, wd);
  endtask

  task automatic wr(input bit ad, input longint unsigned wd);
    cyc(0, 0, 1, ad, wd);
  endtask

  task automatic run(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      bit xt;
      bit bt;
      case (pat)
        0: begin xt = 1; bt = 0; end
        1: begin xt = (i % 3) != 1; bt = (i % 2) == 0; end
        2: begin xt = (i % 2) == 1; bt = (i % 5) != 0; end
        default: begin xt = 1; bt = 1; end
      endcase
      cyc(xt, bt, 0, i[0], 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (2) @(negedge clk);
    reg_addr_i = 0;
    #0.1 check("R1", longint'(timer_o), 0);
    check("R1", longint'(tick_o), 0);
    check("R1", longint'(reg_rdata_o), 0);
    reg_addr_i = 1;
    #0.1 check("R1", longint'(reg_rdata_o), 0);
    rst_ni = 1'b1;
    req = "R1";
    run(4, 3);

    req = "R5";             // prescaler zero: stopped
    run(20, 3);

    req = "R8";             // write in a strobe cycle uses old prescaler
    cyc(1, 1, 1, 1, 64'h8000_0000);
    cyc(1, 0, 0, 0, 0);

    req = "R4";
    run(30, 1);
    wr(1, 64'h4000_0000);
    run(20, 2);
    wr(1, 64'h0000_0001);
    run(10, 1);
    wr(1, 64'h8000_0000);

    req = "R3";
    wr(0, 64'h200);
    run(30, 1);

    req = "R2";
    wr(0, 64'h100);
    run(40, 1);
    run(20, 2);
    wr(0, 64'h000);
    run(20, 2);

    req = "R7";
    wr(0, 64'hFFFF_FFFF);
    run(10, 1);
    wr(0, 64'h0000_0000);

    req = "R6";
    wr(1, 64'hC000_0000);
    run(60, 0);
    wr(1, 64'h9000_0000);
    run(80, 1);
    wr(1, 64'hFFFF_FFFF);
    run(80, 2);
    wr(0, 64'h300);
    wr(1, 64'hA000_0001);
    run(80, 1);

    req = "R8";
    cyc(1, 1, 1, 1, 64'h0);
    run(5, 3);
    cyc(1, 1, 1, 0, 64'h200);
    cyc(1, 1, 1, 1, 64'h8000_0000);
    run(5, 0);

    req = "R9";
    wr(0, 64'h000);
    run(1, 0);
    wr(0, 64'h200);
    run(2100, 0);
    wr(0, 64'h000);
    run(2100, 0);

    req = "R10";
    run(30, 1);
    @(negedge clk);
    cmp_all();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule